// File: doc/BRIEF.md
# Full/Empty Tagged Word Memory

This block is a small register-file memory in which every word carries a one-bit occupancy tag next to its data. A producer deposits values through a write port and a consumer takes them through a read port. Both ports use valid/ready handshakes, and the tag turns each plain access into a blocking synchronization step. A normal write lands only in a word whose tag says empty and marks it full. A normal read is granted only on a word whose tag says full; it returns the data and marks the word empty again. An access whose condition is not met keeps its ready low. The requester holds its request, and the block evaluates it again on every cycle until the tag flips.

Each port also has a raw-mode input. A raw access skips the tag test, is always granted and leaves the tag as it found it. Software or a debug agent can use it to initialise or inspect words without disturbing the synchronization.

When both ports address the same word in one cycle, the read is decided first against the tag as it stood at the start of that cycle. The write is then decided against the tag left by that read. Read data is combinational from the addressed word and is valid in the cycle the read is granted. Reset clears every tag; data contents are not reset.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset every tag is empty, so a normal read (rd_bypass=0) of any address sees rd_ready=0.
- R2: A normal write (wr_bypass=0) to an empty word has wr_ready=1 in that cycle, stores wr_data, and makes the word full from the next cycle.
- R3: A normal write to a full word sees wr_ready=0 and changes neither the stored data nor the tag.
- R4: A normal read of a full word sees rd_ready=1, rd_data equals the stored word in that same cycle, and the word is empty from the next cycle.
- R5: A normal read of an empty word sees rd_ready=0 and leaves the tag unchanged.
- R6: A raw write (wr_bypass=1) always sees wr_ready=1, stores wr_data and leaves the tag unchanged.
- R7: A raw read (rd_bypass=1) always sees rd_ready=1, returns the stored word and leaves the tag unchanged.
- R8: When normal reads and writes target the same word in one cycle, the read is decided on the tag from before the cycle. If the word was full, both are granted: the read returns the old data and the word stays full holding the new data. If it was empty, only the write is granted.
- R9: A blocked request is re-evaluated every cycle. Its ready rises in the first cycle after the tag has changed in its favour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | Producer request present |
| wr_ready | output | 1 | Producer request granted this cycle when valid |
| wr_addr | input | ADDR_W | Producer word address |
| wr_data | input | DATA_W | Producer data |
| wr_bypass | input | 1 | Raw write: skip and keep the tag |
| rd_valid | input | 1 | Consumer request present |
| rd_ready | output | 1 | Consumer request granted this cycle when valid |
| rd_addr | input | ADDR_W | Consumer word address |
| rd_bypass | input | 1 | Raw read: skip and keep the tag |
| rd_data | output | DATA_W | Addressed word, valid when the read is granted |

## Verification
The bench targets the same-word collision in both tag states. A design that resolved the write first would refuse a write to a full word that is being drained, or would let a read take data that was only just written. It holds writes on full words and reads on empty words for several cycles. A design that let them through would overwrite unread data or hand out stale values. Raw accesses are mixed into occupied and vacant words, where any tag change shows up as a wrong grant on a later normal access. A long randomized stretch on a few addresses then compares grants and read data against a behavioural model on every cycle.

// File: rtl/fe_pkg.sv
package fe_pkg;

  typedef enum logic {
    MODE_TAGGED = 1'b0,
    MODE_RAW    = 1'b1
  } fe_mode_e;

  // A tagged write may proceed when the word is empty, or when a tagged
  // read drains the same word in this cycle (read resolves first).
  function automatic logic write_permitted(logic tag_now, logic drained_here);
    return !tag_now || drained_here;
  endfunction

endpackage

// File: rtl/fe_gate.sv
module fe_gate
  import fe_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wr_valid,
  input  logic              wr_bypass,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_tag,
  input  logic              rd_valid,
  input  logic              rd_bypass,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_tag,
  output logic              wr_ready,
  output logic              rd_ready,
  output logic              wr_fire,
  output logic              wr_mark,
  output logic              rd_clear
);

  fe_mode_e wr_mode;
  fe_mode_e rd_mode;
  logic     rd_fire;
  logic     drained_here;

  always_comb begin
    wr_mode      = wr_bypass ? MODE_RAW : MODE_TAGGED;
    rd_mode      = rd_bypass ? MODE_RAW : MODE_TAGGED;
    // read side decided first, on the tag held at the start of the cycle
    rd_ready     = (rd_mode == MODE_RAW) || rd_tag;
    rd_fire      = rd_valid && rd_ready;
    rd_clear     = rd_fire && (rd_mode == MODE_TAGGED);
    drained_here = rd_clear && (rd_addr == wr_addr);
    // write side sees the tag as left by the read
    wr_ready     = (wr_mode == MODE_RAW) || write_permitted(wr_tag, drained_here);
    wr_fire      = wr_valid && wr_ready;
    wr_mark      = wr_fire && (wr_mode == MODE_TAGGED);
  end

endmodule

// File: rtl/fe_tag_bank.sv
module fe_tag_bank #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              set_en,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] clr_addr,
  output logic [DEPTH-1:0]  tags
);

  logic [DEPTH-1:0] tag_q;
  logic [DEPTH-1:0] tag_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_tag
    always_comb begin
      tag_d[i] = tag_q[i];
      if (clr_en && (clr_addr == ADDR_W'(i))) tag_d[i] = 1'b0;
      if (set_en && (set_addr == ADDR_W'(i))) tag_d[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) tag_q[i] <= 1'b0;
      else         tag_q[i] <= tag_d[i];
    end
  end

  assign tags = tag_q;

endmodule

// File: rtl/fe_data_bank.sv
module fe_data_bank #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic word_en;
    assign word_en = we && (waddr == ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (word_en) mem_q[i] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem #(
  parameter  int DATA_W = 16,
  parameter  int DEPTH  = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bypass,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_bypass,
  output logic [DATA_W-1:0] rd_data
);

  logic [1:0]       rst_pipe_q;
  logic             rst_n_sync;
  logic [DEPTH-1:0] tag_vec;
  logic             wr_fire;
  logic             wr_mark;
  logic             rd_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe_q[1];

  fe_gate #(.ADDR_W(ADDR_W)) u_gate (
    .wr_valid  (wr_valid),
    .wr_bypass (wr_bypass),
    .wr_addr   (wr_addr),
    .wr_tag    (tag_vec[wr_addr]),
    .rd_valid  (rd_valid),
    .rd_bypass (rd_bypass),
    .rd_addr   (rd_addr),
    .rd_tag    (tag_vec[rd_addr]),
    .wr_ready  (wr_ready),
    .rd_ready  (rd_ready),
    .wr_fire   (wr_fire),
    .wr_mark   (wr_mark),
    .rd_clear  (rd_clear)
  );

  fe_tag_bank #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_tags (
    .clk      (clk),
    .arst_n   (rst_n_sync),
    .set_en   (wr_mark),
    .set_addr (wr_addr),
    .clr_en   (rd_clear),
    .clr_addr (rd_addr),
    .tags     (tag_vec)
  );

  fe_data_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_data (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

endmodule

// File: rtl/fe_sync_mem_chk.sv
module fe_sync_mem_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              arst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              wr_bypass,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              rd_bypass,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DEPTH-1:0]  tag_vec
);

  logic wr_norm_acc;
  logic rd_norm_acc;
  logic same_word;

  assign wr_norm_acc = wr_valid && wr_ready && !wr_bypass;
  assign rd_norm_acc = rd_valid && rd_ready && !rd_bypass;
  assign same_word   = (wr_addr == rd_addr);

  assert_write_fills_R2: assert property (@(posedge clk) disable iff (!arst_n)
    wr_norm_acc |=> tag_vec[$past(wr_addr)]);

  assert_full_blocks_write_R3: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_valid && !wr_bypass && tag_vec[wr_addr] && !(rd_norm_acc && same_word)) |-> !wr_ready);

  assert_read_drains_R4: assert property (@(posedge clk) disable iff (!arst_n)
    (rd_norm_acc && !(wr_norm_acc && same_word)) |=> !tag_vec[$past(rd_addr)]);

  assert_empty_blocks_read_R5: assert property (@(posedge clk) disable iff (!arst_n)
    rd_norm_acc |-> tag_vec[rd_addr]);

  assert_raw_write_ready_R6: assert property (@(posedge clk) disable iff (!arst_n)
    wr_bypass |-> wr_ready);

  assert_raw_write_keeps_tag_R6: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_valid && wr_bypass && !(rd_norm_acc && same_word))
      |=> (tag_vec[$past(wr_addr)] == $past(tag_vec[wr_addr])));

  assert_raw_read_ready_R7: assert property (@(posedge clk) disable iff (!arst_n)
    rd_bypass |-> rd_ready);

  assert_collision_full_R8: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_valid && rd_valid && !wr_bypass && !rd_bypass && same_word && tag_vec[rd_addr])
      |-> (rd_ready && wr_ready));

endmodule

bind fe_sync_mem fe_sync_mem_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .arst_n    (rst_n_sync),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_bypass (wr_bypass),
  .wr_addr   (wr_addr),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_bypass (rd_bypass),
  .rd_addr   (rd_addr),
  .tag_vec   (tag_vec)
);

// File: tb/fe_sync_mem_bench.sv
`timescale 1ns/1ps
module fe_sync_mem_bench;

  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              clk;
  logic              rst_n;
  logic              wr_valid;
  logic              wr_ready;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              wr_bypass;
  logic              rd_valid;
  logic              rd_ready;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_bypass;
  logic [DATA_W-1:0] rd_data;

  int total;
  int bad;
  bit done;

  // behavioural reference
  bit m_full [DEPTH];
  int m_val  [DEPTH];

  fe_sync_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fe_sync_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_bypass (wr_bypass),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .rd_bypass (rd_bypass),
    .rd_data   (rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare with the model, advance model at posedge
  task automatic step(input bit wv, input int wa, input int wd, input bit wb,
                      input bit rv, input int ra, input bit rb, input string req);
    bit exp_rrdy, rd_acc, tag_seen, exp_wrdy, wr_acc;
    @(negedge clk);
    wr_valid = wv; wr_addr = ADDR_W'(wa); wr_data = DATA_W'(wd); wr_bypass = wb;
    rd_valid = rv; rd_addr = ADDR_W'(ra); rd_bypass = rb;
    #1;
    exp_rrdy = rb || m_full[ra];
    rd_acc   = rv && exp_rrdy;
    tag_seen = m_full[wa] && !(rd_acc && !rb && (ra == wa));
    exp_wrdy = wb || !tag_seen;
    wr_acc   = wv && exp_wrdy;
    if (rv) check(rd_ready == exp_rrdy, req, "rd_ready", int'(rd_ready), int'(exp_rrdy));
    if (wv) check(wr_ready == exp_wrdy, req, "wr_ready", int'(wr_ready), int'(exp_wrdy));
    if (rd_acc) check(int'(rd_data) == m_val[ra], req, "rd_data", int'(rd_data), m_val[ra]);
    @(posedge clk);
    if (rd_acc && !rb) m_full[ra] = 1'b0;
    if (wr_acc) begin
      m_val[wa] = wd;
      if (!wb) m_full[wa] = 1'b1;
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL run-timeout actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; done = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin m_full[i] = 1'b0; m_val[i] = 0; end
    rst_n = 1'b0;
    wr_valid = 1'b0; wr_addr = '0; wr_data = '0; wr_bypass = 1'b0;
    rd_valid = 1'b0; rd_addr = '0; rd_bypass = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: every word empty after reset
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 1, i, 0, "R1");

    // R2 then R4 then R5
    step(1, 3, 16'hA5A5, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 1, 3, 0, "R4");
    step(0, 0, 0, 0, 1, 3, 0, "R5");
    step(1, 3, 16'h1234, 0, 0, 0, 0, "R2");

    // R3 / R9: write on a full word held off for several cycles
    for (int k = 0; k < 3; k++) step(1, 3, 16'h0BAD, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 1, 3, 1, "R3");           // raw peek: data unchanged
    // R8: full-word collision, both granted, old data out
    step(1, 3, 16'h5678, 0, 1, 3, 0, "R8");
    step(0, 0, 0, 0, 1, 3, 0, "R8");           // still full, new data
    // R8: empty-word collision, only write granted
    step(1, 5, 16'h00C3, 0, 1, 5, 0, "R8");
    step(0, 0, 0, 0, 1, 5, 0, "R4");

    // R6 / R7 raw accesses
    step(1, 6, 16'h6666, 1, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 1, 6, 0, "R6");           // tag stayed empty
    step(0, 0, 0, 0, 1, 6, 1, "R7");
    step(1, 2, 16'h2222, 0, 0, 0, 0, "R2");
    step(1, 2, 16'h2BBB, 1, 0, 0, 0, "R6");    // raw write into full word
    step(0, 0, 0, 0, 1, 2, 1, "R7");           // raw read keeps full
    step(0, 0, 0, 0, 1, 2, 0, "R7");           // normal read still granted

    // R9: blocked read rises the cycle after a write fills the word
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 1, 1, 0, "R9");
    step(1, 1, 16'h0111, 0, 1, 1, 0, "R9");
    step(0, 0, 0, 0, 1, 1, 0, "R9");

    // randomized stretch, all words initialised by raw writes first
    for (int i = 0; i < DEPTH; i++) step(1, i, 100 + i, 1, 0, 0, 0, "R6");
    for (int k = 0; k < 400; k++) begin
      step($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 65535),
           ($urandom_range(0, 7) == 0),
           $urandom_range(0, 1), $urandom_range(0, 3),
           ($urandom_range(0, 7) == 0), "R9");
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule